// File: doc/BRIEF.md
# Speculative Load Address Table

This block tracks advanced (speculative) loads so that a later check operation can tell whether the speculation is still valid. Each advanced load records its destination register tag and the 8-byte memory line it read. A store to a line removes every entry that covers that line. A check for a register tag looks the tag up in the table:

- If a live entry exists, the speculation held and the check reports a hit.
- If no live entry exists, the block raises a redirect carrying the recovery address that came with the check.

The table is fully associative and has a parameterised number of entries, 16 by default. There is one entry per register tag, and a newer load to the same tag overwrites the older entry. When a load finds no free entry, the victim is chosen by a rotating pointer. A clear input empties the whole table. A check never consumes its entry. Memory and the load datapath are outside this block.

Top module: `spec_load_table`

## Requirements
- R1: After reset the table is empty: every check misses, and `chk_hit`, `redirect_valid` and `redirect_target` are zero until a check is made.
- R2: An advanced load (`ld_req`) inserts an entry holding `ld_tag` and the line of `ld_addr`. A later check for that tag drives `chk_hit` high for exactly one cycle, in the cycle after the check request.
- R3: A check whose tag has no live entry drives `redirect_valid` high in the cycle after the request, with `redirect_target` equal to the `chk_recover` value given with that check. `chk_hit` stays low in that cycle.
- R4: A store removes every entry whose line matches the store line. The line is address bits [ADDR_W-1:3], so addresses that differ only in bits [2:0] match. Entries on other lines are kept.
- R5: An advanced load to a tag that already has an entry replaces that entry. After the replacement, a store to the old line no longer removes the tag's entry.
- R6: A check leaves the table unchanged, so repeated checks of a live tag keep hitting.
- R7: A load into a full table evicts one entry. Free entries are filled lowest index first, and the victim pointer starts at entry 0 and moves up by one (wrapping) after each eviction. After the table is filled with 16 loads, the 17th load evicts the first-loaded tag and the 18th evicts the second.
- R8: A store and an advanced load in the same cycle act as store first, then insert. The new entry survives even when its line equals the store line.
- R9: `clr` empties the table and sets the victim pointer back to entry 0. It is applied before a store or advanced load in the same cycle, so a load in the clear cycle is kept.
- R10: A check sees the table as it stood before any load, store or clear made in the same cycle.
- R11: In a cycle after which no check was requested, `chk_hit` and `redirect_valid` are low and `redirect_target` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Invalidate all entries |
| ld_req | input | 1 | Advanced load request |
| ld_tag | input | TAG_W | Destination register tag of the load |
| ld_addr | input | ADDR_W | Load address |
| st_req | input | 1 | Store request |
| st_addr | input | ADDR_W | Store address |
| chk_req | input | 1 | Check request |
| chk_tag | input | TAG_W | Register tag being checked |
| chk_recover | input | ADDR_W | Recovery code address for this check |
| chk_hit | output | 1 | Speculation held (registered) |
| redirect_valid | output | 1 | Branch to recovery code (registered) |
| redirect_target | output | ADDR_W | Recovery address when redirecting |

## Verification
Every result comes from one register stage. A check is driven before a rising edge, and its outcome is read at the falling edge that follows that same edge. A load, store or clear takes effect at the edge where it is sampled, so it is seen by a check driven in the next cycle, and R10 is covered by a check driven in the same cycle as the load. Inputs change only at falling edges, and outputs are sampled half a cycle after the edge that produced them, so no comparison depends on process order.

// File: rtl/slt_pkg.sv
// Package: shared defaults and types for the speculative load table.
// Assumes: consumers override widths through module parameters only.
package slt_pkg;
    localparam int DEF_ENTRIES   = 16;
    localparam int DEF_TAG_W     = 7;
    localparam int DEF_ADDR_W    = 32;
    localparam int DEF_GRAN_BITS = 3;

    // Where an advanced load lands in the table.
    typedef enum logic [1:0] {
        INS_SAME_TAG = 2'd0,
        INS_FREE     = 2'd1,
        INS_EVICT    = 2'd2
    } ins_kind_e;
endpackage

// File: rtl/slt_match.sv
// Module: slt_match
// Compares every entry against the store line, the load tag and the check tag.
// Assumes: the vectors it returns are not masked by valid; the caller masks them.
module slt_match #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 7,
    parameter int LINE_W  = 29
) (
    input  logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag,
    input  logic [ENTRIES-1:0][LINE_W-1:0] ent_line,
    input  logic [LINE_W-1:0]              st_line,
    input  logic [TAG_W-1:0]               ld_tag,
    input  logic [TAG_W-1:0]               chk_tag,
    output logic [ENTRIES-1:0]             st_line_hit,
    output logic [ENTRIES-1:0]             ld_tag_hit,
    output logic [ENTRIES-1:0]             chk_tag_hit
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        // Per-entry comparators.
        always_comb begin
            st_line_hit[e] = (ent_line[e] == st_line);
            ld_tag_hit[e]  = (ent_tag[e] == ld_tag);
            chk_tag_hit[e] = (ent_tag[e] == chk_tag);
        end
    end
endmodule

// File: rtl/slt_alloc.sv
// Module: slt_alloc
// Picks the entry an advanced load writes. Order of preference: the live entry
// that already holds the same tag, then the lowest free entry, then the entry
// under the rotating victim pointer.
// Assumes: same_tag has at most one bit set; free_vec reflects the table after
// this cycle's clear and store.
module slt_alloc
    import slt_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               ld_req,
    input  logic [ENTRIES-1:0] same_tag,
    input  logic [ENTRIES-1:0] free_vec,
    output logic [IDX_W-1:0]   ins_idx,
    output ins_kind_e          ins_kind
);
    logic [IDX_W-1:0] victim_q;
    logic [IDX_W-1:0] same_idx;
    logic [IDX_W-1:0] free_idx;

    // Encode the same-tag hit and the lowest free entry (lowest index wins).
    always_comb begin
        same_idx = '0;
        free_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (same_tag[e]) same_idx = IDX_W'(e);
            if (free_vec[e]) free_idx = IDX_W'(e);
        end
    end

    // Choose the slot and how it was found.
    always_comb begin
        if (|same_tag) begin
            ins_kind = INS_SAME_TAG;
            ins_idx  = same_idx;
        end else if (|free_vec) begin
            ins_kind = INS_FREE;
            ins_idx  = free_idx;
        end else begin
            ins_kind = INS_EVICT;
            ins_idx  = victim_q;
        end
    end

    // Rotate the victim pointer on each eviction; clear sets it back to entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            victim_q <= '0;
        end else if (ld_req && ins_kind == INS_EVICT) begin
            victim_q <= (victim_q == IDX_W'(ENTRIES - 1)) ? '0 : victim_q + 1'b1;
        end
    end

    // The pointer never leaves the table (R7).
    assert_victim_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        victim_q <= IDX_W'(ENTRIES - 1));
    // A load into a full table moves the pointer on by one (R7).
    assert_victim_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !clr && ins_kind == INS_EVICT && victim_q != IDX_W'(ENTRIES - 1))
        |=> (victim_q == $past(victim_q) + 1'b1));
endmodule

// File: rtl/spec_load_table.sv
// Module: spec_load_table (top)
// Associative table of advanced loads keyed by register tag. A check looks up
// its tag and either reports a hit or redirects to the recovery address.
// Assumes: one request of each kind per cycle. Within a cycle the order is
// check (sees old state), then clear, then store, then insert.
module spec_load_table
    import slt_pkg::*;
#(
    parameter int ENTRIES   = DEF_ENTRIES,
    parameter int TAG_W     = DEF_TAG_W,
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int GRAN_BITS = DEF_GRAN_BITS,
    localparam int LINE_W   = ADDR_W - GRAN_BITS,
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld_req,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_req,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_req,
    input  logic [TAG_W-1:0]  chk_tag,
    input  logic [ADDR_W-1:0] chk_recover,
    output logic              chk_hit,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_target
);
    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
    logic [ENTRIES-1:0][LINE_W-1:0] line_q;

    logic [ENTRIES-1:0] st_line_hit, ld_tag_hit, chk_tag_hit;
    logic [ENTRIES-1:0] valid_mid, same_tag_live;
    logic [IDX_W-1:0]   ins_idx;
    ins_kind_e          ins_kind;
    logic               lookup_hit;

    slt_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_match (
        .ent_tag    (tag_q),
        .ent_line   (line_q),
        .st_line    (st_addr[ADDR_W-1:GRAN_BITS]),
        .ld_tag     (ld_tag),
        .chk_tag    (chk_tag),
        .st_line_hit(st_line_hit),
        .ld_tag_hit (ld_tag_hit),
        .chk_tag_hit(chk_tag_hit)
    );

    // Validity after this cycle's clear and store, before the insert.
    always_comb begin
        valid_mid = clr ? '0 : valid_q;
        if (st_req) valid_mid = valid_mid & ~st_line_hit;
        same_tag_live = clr ? '0 : (valid_q & ld_tag_hit);
        lookup_hit    = |(valid_q & chk_tag_hit);
    end

    slt_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .ld_req  (ld_req),
        .same_tag(same_tag_live),
        .free_vec(~valid_mid),
        .ins_idx (ins_idx),
        .ins_kind(ins_kind)
    );

    // Table state update: clear, store removal, then insert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
            line_q  <= '0;
        end else begin
            valid_q <= valid_mid;
            if (ld_req) begin
                valid_q[ins_idx] <= 1'b1;
                tag_q[ins_idx]   <= ld_tag;
                line_q[ins_idx]  <= ld_addr[ADDR_W-1:GRAN_BITS];
            end
        end
    end

    // Registered check outcome, computed from the table state before this cycle's updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_hit         <= 1'b0;
            redirect_valid  <= 1'b0;
            redirect_target <= '0;
        end else begin
            chk_hit         <= chk_req && lookup_hit;
            redirect_valid  <= chk_req && !lookup_hit;
            redirect_target <= (chk_req && !lookup_hit) ? chk_recover : '0;
        end
    end

    // A check always produces exactly one outcome in the next cycle (R2, R3).
    assert_check_answers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |=> (chk_hit != redirect_valid));
    // No outcome without a check (R11).
    assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_req |=> (!chk_hit && !redirect_valid && redirect_target == '0));
    // After a store with no insert, no live entry holds the stored line (R4).
    assert_store_purges_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !ld_req) |=> ((valid_q & st_line_hit) == '0 || $changed(st_addr)));
    // A clear with no load leaves the table empty (R9).
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ld_req) |=> (valid_q == '0));
    // An advanced load always leaves a live entry with its tag (R2).
    assert_load_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !$isunknown(ld_tag)) |=> (|(valid_q & ld_tag_hit) || $changed(ld_tag)));
    // Each tag occupies at most one live entry (R5).
    assert_tag_unique_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(valid_q & chk_tag_hit) <= 1);
endmodule

// File: tb/test_spec_load_table.sv
// Directed bench: one task per scenario, each checking its own results.
module test_spec_load_table;
    localparam int TAG_W  = 7;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic              ld_req = 1'b0;
    logic [TAG_W-1:0]  ld_tag = '0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic              st_req = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic              chk_req = 1'b0;
    logic [TAG_W-1:0]  chk_tag = '0;
    logic [ADDR_W-1:0] chk_recover = '0;
    logic              chk_hit;
    logic              redirect_valid;
    logic [ADDR_W-1:0] redirect_target;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    spec_load_table i_spec_load_table (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .ld_req(ld_req), .ld_tag(ld_tag), .ld_addr(ld_addr),
        .st_req(st_req), .st_addr(st_addr),
        .chk_req(chk_req), .chk_tag(chk_tag), .chk_recover(chk_recover),
        .chk_hit(chk_hit), .redirect_valid(redirect_valid),
        .redirect_target(redirect_target)
    );

    // Compare one value and report a mismatch.
    task automatic expect_eq(input string req, input string what,
                             input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Let one rising edge sample the driven inputs, return at the next falling edge and drop all requests.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0; ld_req = 1'b0; st_req = 1'b0; chk_req = 1'b0;
    endtask

    task automatic drive_load(input logic [TAG_W-1:0] t, input logic [ADDR_W-1:0] a);
        ld_req = 1'b1; ld_tag = t; ld_addr = a;
    endtask

    task automatic drive_store(input logic [ADDR_W-1:0] a);
        st_req = 1'b1; st_addr = a;
    endtask

    task automatic drive_check(input logic [TAG_W-1:0] t, input logic [ADDR_W-1:0] rec);
        chk_req = 1'b1; chk_tag = t; chk_recover = rec;
    endtask

    // Issue a check alone and compare the outcome due in the next cycle.
    task automatic check_tag(input string req, input logic [TAG_W-1:0] t, input logic exp_hit);
        logic [ADDR_W-1:0] rec;
        rec = 32'h8000_0000 | {25'd0, t};
        drive_check(t, rec);
        step();
        expect_eq(req, "chk_hit", {31'd0, chk_hit}, {31'd0, exp_hit});
        expect_eq(req, "redirect_valid", {31'd0, redirect_valid}, {31'd0, !exp_hit});
        expect_eq(req, "redirect_target", redirect_target, exp_hit ? '0 : rec);
    endtask

    task automatic do_load(input logic [TAG_W-1:0] t, input logic [ADDR_W-1:0] a);
        drive_load(t, a); step();
    endtask

    task automatic do_store(input logic [ADDR_W-1:0] a);
        drive_store(a); step();
    endtask

    task automatic do_clear();
        clr = 1'b1; step();
    endtask

    task automatic t_reset();
        expect_eq("R1", "chk_hit at reset", {31'd0, chk_hit}, '0);
        expect_eq("R1", "redirect at reset", {31'd0, redirect_valid}, '0);
        check_tag("R1", 7'd3, 1'b0);
    endtask

    task automatic t_insert_and_hit();
        do_load(7'd10, 32'h0000_1000);
        check_tag("R2", 7'd10, 1'b1);
        // The hit pulse lasts one cycle only.
        step();
        expect_eq("R2", "hit pulse width", {31'd0, chk_hit}, '0);
        check_tag("R3", 7'd11, 1'b0);
    endtask

    task automatic t_store_granularity();
        do_load(7'd20, 32'h0000_2000);
        do_load(7'd21, 32'h0000_2004);
        do_load(7'd22, 32'h0000_2008);
        do_store(32'h0000_2007);
        check_tag("R4", 7'd20, 1'b0);
        check_tag("R4", 7'd21, 1'b0);
        check_tag("R4", 7'd22, 1'b1);
    endtask

    task automatic t_same_tag_replace();
        do_load(7'd30, 32'h0000_3000);
        do_load(7'd30, 32'h0000_3100);
        do_store(32'h0000_3000);
        check_tag("R5", 7'd30, 1'b1);
        do_store(32'h0000_3100);
        check_tag("R5", 7'd30, 1'b0);
    endtask

    task automatic t_check_keeps();
        do_load(7'd40, 32'h0000_4000);
        check_tag("R6", 7'd40, 1'b1);
        check_tag("R6", 7'd40, 1'b1);
    endtask

    task automatic t_store_then_insert();
        do_load(7'd50, 32'h0000_5000);
        drive_store(32'h0000_5000);
        drive_load(7'd51, 32'h0000_5000);
        step();
        check_tag("R8", 7'd50, 1'b0);
        check_tag("R8", 7'd51, 1'b1);
    endtask

    task automatic t_check_sees_old();
        drive_load(7'd60, 32'h0000_6000);
        drive_check(7'd60, 32'h0000_6666);
        step();
        expect_eq("R10", "redirect_valid", {31'd0, redirect_valid}, 32'd1);
        expect_eq("R10", "redirect_target", redirect_target, 32'h0000_6666);
        check_tag("R10", 7'd60, 1'b1);
    endtask

    task automatic t_idle_quiet();
        drive_load(7'd61, 32'h0000_6100);
        step();
        expect_eq("R11", "chk_hit idle", {31'd0, chk_hit}, '0);
        expect_eq("R11", "redirect_valid idle", {31'd0, redirect_valid}, '0);
        expect_eq("R11", "redirect_target idle", redirect_target, '0);
    endtask

    task automatic t_clear();
        do_load(7'd70, 32'h0000_7000);
        clr = 1'b1;
        drive_load(7'd71, 32'h0000_7100);
        step();
        check_tag("R9", 7'd70, 1'b0);
        check_tag("R9", 7'd40, 1'b0);
        check_tag("R9", 7'd71, 1'b1);
    endtask

    task automatic t_round_robin();
        do_clear();
        for (int i = 0; i < 16; i++) do_load(7'(i), 32'h0001_0000 + 32'(i) * 32'h100);
        check_tag("R7", 7'd0, 1'b1);
        do_load(7'd100, 32'h0002_0000);
        check_tag("R7", 7'd0, 1'b0);
        check_tag("R7", 7'd1, 1'b1);
        do_load(7'd101, 32'h0002_0100);
        check_tag("R7", 7'd1, 1'b0);
        check_tag("R7", 7'd2, 1'b1);
        check_tag("R7", 7'd15, 1'b1);
        check_tag("R7", 7'd100, 1'b1);
        check_tag("R7", 7'd101, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_insert_and_hit();
        t_store_granularity();
        t_same_tag_replace();
        t_check_keeps();
        t_store_then_insert();
        t_check_sees_old();
        t_idle_quiet();
        t_clear();
        t_round_robin();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule